// File: doc/BRIEF.md
# Dual-Band 2x Halfband Interpolator

This block doubles the sample rate of a signed real sample stream that feeds a converter output which updates on both clock edges. For each input sample taken at the clock rate it produces a pair of output samples: the rising-edge lane carries the input sample itself, and the falling-edge lane carries a newly computed sample halfway between it and the next one. The data rate at the input does not change with the band choice; only the computed lane differs.

The falling-edge sample comes from a symmetric halfband filter whose centre tap is exactly one half, so the rising-edge lane is a plain delayed copy of the input. A band select input picks between a lowpass response (the signal sits below 0.4 of the input clock rate and the image above 0.6 is removed) and a highpass response (the signal sits above 0.6 and the image below 0.4 is removed). The highpass response reuses the lowpass coefficients with every tap at an odd offset from the centre sign-flipped. The transition region between 0.4 and 0.6 of the clock rate is only weakly controlled. Both lanes leave the block a fixed number of clock cycles after their input, in either band.

Top module: `hb_interp2x`

## Requirements
- R1: A valid input sample sampled at clock edge k appears unchanged on `out_rise` after edge k+LATENCY (default 97), with `out_valid` high; no output is valid within LATENCY edges after reset is released.
- R2: With `band_sel` = 0 (lowpass), `out_fall` paired with input sample x[m] equals floor((S + 128) / 256) with S = 150*(x[m]+x[m+1]) - 25*(x[m-1]+x[m+2]) + 3*(x[m-2]+x[m+3]), where x[m+j] is the sample taken j valid-or-invalid clocks later.
- R3: With `band_sel` = 1 (highpass), `out_fall` equals floor((-S + 128) / 256), the same sum with all odd-offset taps negated.
- R4: The falling-edge result saturates to the signed 16-bit range [-32768, 32767] instead of wrapping.
- R5: For a constant input D, in lowpass `out_fall` equals D; in highpass `out_fall` equals -D (saturated), so the two lanes sum to zero.
- R6: An input taken while `in_valid` is low counts as a zero sample in the filter, and its output slot has `out_valid` low.
- R7: After the clock edge at which `band_sel` differs from its previous value, `out_valid` stays low for exactly LATENCY edges; the first valid output afterwards is computed entirely in the new band.
- R8: While `rst_n` is low at a clock edge, all outputs become zero and `out_valid` low from that edge on.
- R9: The latency from input to both output lanes is the same LATENCY in both bands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_sample | input | 16 | Signed input sample |
| in_valid | input | 1 | High when `in_sample` carries a sample |
| band_sel | input | 1 | 0 = lowpass response, 1 = highpass response |
| out_rise | output | 16 | Signed sample for the rising-edge slot (delayed input) |
| out_fall | output | 16 | Signed interpolated sample for the falling-edge slot |
| out_valid | output | 1 | High when both output lanes hold a sample |

## Verification
The assertions take for granted that `rst_n` is low at the first clock edges, and that `in_valid` and `band_sel` are known and change only between rising edges, since the flush and gap windows are counted from the edge at which a change is sampled. The stimulus drives every input on the falling edge, holds reset for several cycles at start and once mid-stream, and changes band only while data flows so that each flush window is seen complete and then released.

// File: rtl/hbi_pkg.sv
// Shared constants, band type and coefficient set for the 2x halfband
// interpolator. Assumes a halfband whose centre tap is exactly 1/2 and whose
// non-zero side taps sit at odd offsets; only one side is stored.
package hbi_pkg;

    localparam int HB_PAIRS  = 3;   // non-zero symmetric tap pairs
    localparam int HB_COEF_W = 10;  // signed coefficient width
    localparam int HB_FRAC   = 8;   // coefficient fraction bits (1.0 = 256)

    typedef enum logic {
        BAND_LOW  = 1'b0,
        BAND_HIGH = 1'b1
    } band_e;

    // Side-tap coefficient for pair k (offset +/-(2k+1) half-samples from centre).
    function automatic logic signed [HB_COEF_W-1:0] hb_coef(input int k);
        case (k)
            0:       return 10'sd150;
            1:       return -10'sd25;
            2:       return 10'sd3;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/hbi_tapline.sv
// Input sample history for the halfband filter. Invalid samples enter as zero
// so the filter sees a gap as silence; a valid flag travels with each tap.
// Assumes one input slot per clock.
module hbi_tapline #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [DATA_W-1:0]              din,
    input  logic                           din_valid,
    output logic [DEPTH-1:0][DATA_W-1:0]   taps,
    output logic [DEPTH-1:0]               tap_valid
);

    // Shift one slot per clock; tap 0 is the newest sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps      <= '0;
            tap_valid <= '0;
        end else begin
            taps[0]      <= din_valid ? din : '0;
            tap_valid[0] <= din_valid;
            for (int j = 1; j < DEPTH; j++) begin
                taps[j]      <= taps[j-1];
                tap_valid[j] <= tap_valid[j-1];
            end
        end
    end

endmodule

// File: rtl/hbi_mac.sv
// Two-stage symmetric halfband arithmetic. Stage 1 folds each tap pair and
// multiplies by its coefficient; stage 2 sums, applies the band sign, rounds
// half up and saturates. The centre sample rides alongside as the rising lane.
// Assumes taps are ordered newest first with the centre at index PAIRS.
module hbi_mac
    import hbi_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PAIRS  = HB_PAIRS,
    parameter int COEF_W = HB_COEF_W,
    parameter int FRAC   = HB_FRAC
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [2*PAIRS-1:0][DATA_W-1:0]    taps,
    input  logic [2*PAIRS-1:0]                tap_valid,
    input  band_e                             band,
    output logic signed [DATA_W-1:0]          rise,
    output logic signed [DATA_W-1:0]          fall,
    output logic                              valid
);

    localparam int SUM_W  = DATA_W + 1;
    localparam int PROD_W = SUM_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(PAIRS) + 2;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(2 ** (FRAC - 1));
    localparam logic signed [ACC_W-1:0] MAXV =
        {{(ACC_W - DATA_W + 1){1'b0}}, {(DATA_W - 1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MINV = ~MAXV;

    logic signed [PAIRS-1:0][PROD_W-1:0] prod;
    logic signed [PAIRS-1:0][PROD_W-1:0] prod_q;
    logic signed [DATA_W-1:0]            rise_s1;
    logic                                valid_s1;
    logic signed [ACC_W-1:0]             acc;
    logic signed [ACC_W-1:0]             acc_signed;
    logic signed [ACC_W-1:0]             rounded;
    logic signed [DATA_W-1:0]            fall_next;

    // One folded multiply per symmetric pair.
    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        logic signed [SUM_W-1:0] pair_sum;
        assign pair_sum = SUM_W'($signed(taps[PAIRS-1-k])) + SUM_W'($signed(taps[PAIRS+k]));
        assign prod[k]  = PROD_W'(pair_sum) * PROD_W'(hb_coef(k));
    end

    // Stage 1: register products and the centre sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q   <= '0;
            rise_s1  <= '0;
            valid_s1 <= 1'b0;
        end else begin
            prod_q   <= prod;
            rise_s1  <= $signed(taps[PAIRS]);
            valid_s1 <= tap_valid[PAIRS];
        end
    end

    // Sum, band sign, round half up and clamp to the output range.
    always_comb begin
        acc = '0;
        for (int k = 0; k < PAIRS; k++) begin
            acc = acc + ACC_W'($signed(prod_q[k]));
        end
        acc_signed = (band == BAND_HIGH) ? -acc : acc;
        rounded    = (acc_signed + HALF) >>> FRAC;
        if (rounded > MAXV) begin
            fall_next = MAXV[DATA_W-1:0];
        end else if (rounded < MINV) begin
            fall_next = MINV[DATA_W-1:0];
        end else begin
            fall_next = rounded[DATA_W-1:0];
        end
    end

    // Stage 2: register both lanes and their flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise  <= '0;
            fall  <= '0;
            valid <= 1'b0;
        end else begin
            rise  <= rise_s1;
            fall  <= fall_next;
            valid <= valid_s1;
        end
    end

endmodule

// File: rtl/hbi_delay.sv
// Plain register delay line used to pad the datapath to its fixed latency.
// Assumes STAGES >= 0; zero stages is a wire.
module hbi_delay #(
    parameter int WIDTH  = 33,
    parameter int STAGES = 92
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    if (STAGES == 0) begin : g_wire
        assign q = d;
    end else begin : g_regs
        logic [STAGES-1:0][WIDTH-1:0] pipe;

        // Advance every stage by one each clock.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe <= '0;
            end else begin
                pipe[0] <= d;
                for (int s = 1; s < STAGES; s++) begin
                    pipe[s] <= pipe[s-1];
                end
            end
        end

        assign q = pipe[STAGES-1];
    end

endmodule

// File: rtl/hbi_band_ctl.sv
// Registers the band select and closes the output gate for LATENCY clocks
// after any change, so no output mixes samples filtered in two bands.
// Assumes band_sel is synchronous to clk.
module hbi_band_ctl
    import hbi_pkg::*;
#(
    parameter int LATENCY = 97
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  band_sel,
    output band_e band_q,
    output logic  gate_open
);

    localparam int CNT_W = $clog2(LATENCY + 1);

    logic [CNT_W-1:0] hold;

    // Track the band and count down the flush window after a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            band_q <= BAND_LOW;
            hold   <= '0;
        end else if (band_e'(band_sel) != band_q) begin
            band_q <= band_e'(band_sel);
            hold   <= CNT_W'(LATENCY);
        end else if (hold != '0) begin
            hold <= hold - 1'b1;
        end
    end

    assign gate_open = (hold == '0);

endmodule

// File: rtl/hb_interp2x.sv
// Top of the 2x halfband interpolator: tap history, folded arithmetic, a pad
// delay to a fixed total latency, and the band flush gate. Assumes LATENCY is
// larger than the arithmetic depth (HB_PAIRS + 2 clocks).
module hb_interp2x
    import hbi_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int LATENCY = 97
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              in_valid,
    input  logic              band_sel,
    output logic [DATA_W-1:0] out_rise,
    output logic [DATA_W-1:0] out_fall,
    output logic              out_valid
);

    localparam int TAPS     = 2 * HB_PAIRS;
    localparam int CORE_LAT = HB_PAIRS + 2;
    localparam int PAD      = LATENCY - CORE_LAT;
    localparam int BUS_W    = 2 * DATA_W + 1;

    logic [TAPS-1:0][DATA_W-1:0] taps;
    logic [TAPS-1:0]             tap_valid;
    band_e                       band_q;
    logic                        gate_open;
    logic signed [DATA_W-1:0]    core_rise;
    logic signed [DATA_W-1:0]    core_fall;
    logic                        core_valid;
    logic [BUS_W-1:0]            pad_in;
    logic [BUS_W-1:0]            pad_out;

    hbi_tapline #(
        .DATA_W (DATA_W),
        .DEPTH  (TAPS)
    ) u_taps (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (in_sample),
        .din_valid (in_valid),
        .taps      (taps),
        .tap_valid (tap_valid)
    );

    hbi_band_ctl #(
        .LATENCY (LATENCY)
    ) u_band (
        .clk       (clk),
        .rst_n     (rst_n),
        .band_sel  (band_sel),
        .band_q    (band_q),
        .gate_open (gate_open)
    );

    hbi_mac #(
        .DATA_W (DATA_W)
    ) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .taps      (taps),
        .tap_valid (tap_valid),
        .band      (band_q),
        .rise      (core_rise),
        .fall      (core_fall),
        .valid     (core_valid)
    );

    assign pad_in = {core_valid, core_rise, core_fall};

    hbi_delay #(
        .WIDTH  (BUS_W),
        .STAGES (PAD)
    ) u_pad (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_out)
    );

    assign out_rise  = pad_out[2*DATA_W-1:DATA_W];
    assign out_fall  = pad_out[DATA_W-1:0];
    assign out_valid = pad_out[BUS_W-1] & gate_open;

endmodule

// File: rtl/hb_interp2x_chk.sv
// Port-level checker for hb_interp2x: reset clearing, start-up quiet time,
// band-change flush window and invalid-input gaps. Assumes inputs change only
// between rising edges and rst_n starts low.
module hb_interp2x_chk #(
    parameter int DATA_W  = 16,
    parameter int LATENCY = 97
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              band_sel,
    input logic [DATA_W-1:0] out_rise,
    input logic [DATA_W-1:0] out_fall,
    input logic              out_valid
);

    localparam int CW = $clog2(LATENCY + 2) + 1;
    localparam logic [CW-1:0] LAT_C = CW'(LATENCY);

    logic          past_rst_low = 1'b0;
    logic          band_prev;
    logic [CW-1:0] since_reset;
    logic [CW-1:0] since_change;
    logic [CW-1:0] gap_age;

    // Reset clears every output from the following edge on.
    always_ff @(posedge clk) begin
        if (past_rst_low) begin
            AST_RESET_CLEAR: assert (!out_valid && out_rise == '0 && out_fall == '0)  // R8
                else $error("outputs not cleared by reset");
        end
        past_rst_low <= !rst_n;
    end

    // Age counters for reset, band change and the most recent input gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            band_prev    <= 1'b0;
            since_reset  <= '0;
            since_change <= LAT_C;
            gap_age      <= '0;
        end else begin
            band_prev    <= band_sel;
            since_reset  <= (since_reset > LAT_C) ? since_reset : since_reset + 1'b1;
            since_change <= (band_sel != band_prev) ? '0 :
                            (since_change > LAT_C) ? since_change : since_change + 1'b1;
            gap_age      <= !in_valid ? '0 :
                            (gap_age > LAT_C) ? gap_age : gap_age + 1'b1;
        end
    end

    AST_STARTUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (since_reset <= LAT_C) |-> !out_valid);  // R1

    AST_FLUSH_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (band_sel != $past(band_sel)) |=> !out_valid);  // R7

    AST_FLUSH_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (since_change < LAT_C) |-> !out_valid);  // R7

    AST_GAP_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_age == LAT_C) |-> !out_valid);  // R6

endmodule

bind hb_interp2x hb_interp2x_chk #(
    .DATA_W  (DATA_W),
    .LATENCY (LATENCY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .band_sel  (band_sel),
    .out_rise  (out_rise),
    .out_fall  (out_fall),
    .out_valid (out_valid)
);

// File: tb/sim_hb_interp2x.sv
module sim_hb_interp2x;

    localparam int LAT  = 97;
    localparam int HMAX = 8191;
    localparam int P    = 32767;
    localparam int N    = -32768;
    // Impulse table walked in lowpass: {input, expected rise, expected fall}
    localparam int IMP [12][3] = '{
        '{0,    0,    12},  '{0,    0,  -100}, '{0,    0,   600},
        '{1024, 1024, 600}, '{0,    0,  -100}, '{0,    0,     6},
        '{0,    0,    50},  '{0,    0,  -300}, '{-512, -512, -300},
        '{0,    0,    50},  '{0,    0,    -6}, '{0,    0,     0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_sample = '0;
    logic        in_valid = 1'b0;
    logic        band_sel = 1'b0;
    logic [15:0] out_rise;
    logic [15:0] out_fall;
    logic        out_valid;

    int n_chk = 0;
    int n_fail = 0;
    int ecnt = 0;
    int last_chg = -1000;
    int last_rst = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    int hx [0:HMAX];
    bit hv [0:HMAX];
    bit hm [0:HMAX];
    logic [15:0] lf = 16'hACE1;

    always #5 clk = ~clk;

    hb_interp2x u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_sample (in_sample),
        .in_valid  (in_valid),
        .band_sel  (band_sel),
        .out_rise  (out_rise),
        .out_fall  (out_fall),
        .out_valid (out_valid)
    );

    // Record what the block sampled at each rising edge.
    always @(posedge clk) begin
        ecnt = ecnt + 1;
        if (ecnt <= HMAX) begin
            hv[ecnt] = rst_n && in_valid;
            hx[ecnt] = hv[ecnt] ? int'($signed(in_sample)) : 0;
            hm[ecnt] = rst_n ? band_sel : 1'b0;
            if (!rst_n) last_rst = ecnt;
            if (ecnt > 1 && hm[ecnt] != hm[ecnt-1]) last_chg = ecnt;
        end
    end

    function automatic int xs(input int e, input int lo);
        if (e <= lo || e < 1 || e > HMAX) return 0;
        return hx[e];
    endfunction

    function automatic int sat16(input int v);
        if (v > P) return P;
        if (v < N) return N;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at edge %0d", req, act, exp, ecnt);
        end
    endtask

    // Reference model compared on every cycle once history is deep enough.
    always @(negedge clk) begin
        if (mon_en && ecnt > LAT + 4 && ecnt <= HMAX) begin
            int e;
            int s;
            int sum;
            int ef;
            bit ev;
            e  = ecnt;
            s  = e - LAT;
            ev = hv[s] && (s > last_rst) && (e - last_chg >= LAT);
            check(out_valid == ev, (e - last_chg < LAT + 2) ? "R7 valid" : "R6 valid",
                  int'(out_valid), int'(ev));
            if (ev && out_valid) begin
                sum = 150 * (xs(s, last_rst) + xs(s+1, last_rst))
                    - 25 * (xs(s-1, last_rst) + xs(s+2, last_rst))
                    + 3 * (xs(s-2, last_rst) + xs(s+3, last_rst));
                if (hm[e]) sum = -sum;
                ef = (sum + 128) >>> 8;
                check(int'($signed(out_rise)) == hx[s], "R1 rise lane",
                      int'($signed(out_rise)), hx[s]);
                check(int'($signed(out_fall)) == sat16(ef),
                      (ef != sat16(ef)) ? "R4 saturate" : (hm[e] ? "R3 highpass" : "R2 lowpass"),
                      int'($signed(out_fall)), sat16(ef));
            end
        end
    end

    task automatic put(input int v, input bit val, input int n);
        repeat (n) begin
            @(negedge clk);
            in_sample = 16'(v);
            in_valid  = val;
        end
    endtask

    task automatic wait_edge(input int target);
        do @(negedge clk); while (ecnt < target);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        int e0;
        int eg;
        repeat (4) @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0, "R8 reset valid", int'(out_valid), 0);
        check(out_rise == '0 && out_fall == '0, "R8 reset data", int'(out_fall), 0);
        rst_n  = 1'b1;
        mon_en = 1'b1;

        // R1/R2: impulse table in lowpass
        put(0, 1'b1, 110);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (i == 0) e0 = ecnt + 1;
            in_sample = 16'(IMP[i][0]);
            in_valid  = 1'b1;
        end
        put(0, 1'b1, 1);
        for (int i = 0; i < 12; i++) begin
            wait_edge(e0 + i + LAT);
            check(out_valid == 1'b1, "R1 table valid", int'(out_valid), 1);
            check(int'($signed(out_rise)) == IMP[i][1], "R1 table rise",
                  int'($signed(out_rise)), IMP[i][1]);
            check(int'($signed(out_fall)) == IMP[i][2], "R2 table fall",
                  int'($signed(out_fall)), IMP[i][2]);
        end

        // R5: DC in lowpass
        put(8000, 1'b1, 120);
        check(int'($signed(out_fall)) == 8000 && int'($signed(out_rise)) == 8000,
              "R5 lowpass DC", int'($signed(out_fall)), 8000);

        // R7: band change flush, then R5 highpass DC
        @(negedge clk);
        band_sel = 1'b1;
        eg = ecnt + 1;
        wait_edge(eg + LAT - 1);
        check(out_valid == 1'b0, "R7 flush end", int'(out_valid), 0);
        wait_edge(eg + LAT);
        check(out_valid == 1'b1, "R7 reopen", int'(out_valid), 1);
        check(int'($signed(out_fall)) == -8000, "R5 highpass DC", int'($signed(out_fall)), -8000);
        check(int'($signed(out_rise)) + int'($signed(out_fall)) == 0, "R5 lane sum",
              int'($signed(out_rise)) + int'($signed(out_fall)), 0);

        // R4: highpass DC at the negative limit
        put(N, 1'b1, 120);
        check(int'($signed(out_fall)) == P, "R4 DC clamp", int'($signed(out_fall)), P);

        // R4: alternating burst that overflows negative in highpass
        put(0, 1'b1, 10);
        @(negedge clk);
        eg = ecnt + 1;
        in_sample = 16'(P);
        put(N, 1'b1, 1); put(P, 1'b1, 2); put(N, 1'b1, 1); put(P, 1'b1, 1);
        put(0, 1'b1, 1);
        wait_edge(eg + 2 + LAT);
        check(int'($signed(out_fall)) == N, "R4 burst clamp", int'($signed(out_fall)), N);

        // R9/R3: highpass impulse keeps the same latency
        put(0, 1'b1, 10);
        @(negedge clk);
        eg = ecnt + 1;
        in_sample = 16'd1000;
        put(0, 1'b1, 1);
        wait_edge(eg + LAT);
        check(int'($signed(out_rise)) == 1000, "R9 highpass latency", int'($signed(out_rise)), 1000);
        check(int'($signed(out_fall)) == -586, "R3 highpass impulse", int'($signed(out_fall)), -586);

        // R6: single invalid slot in lowpass
        @(negedge clk);
        band_sel = 1'b0;
        put(100, 1'b1, 110);
        @(negedge clk);
        eg = ecnt + 1;
        in_valid = 1'b0;
        put(100, 1'b1, 1);
        wait_edge(eg + LAT);
        check(out_valid == 1'b0, "R6 gap slot", int'(out_valid), 0);
        wait_edge(eg + LAT + 1);
        check(out_valid == 1'b1, "R6 after gap", int'(out_valid), 1);

        // R2/R3/R6: pseudo-random data with gaps in both bands
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            in_sample = lf;
            in_valid  = (lf[3:0] != 4'd5);
            if (i == 350) band_sel = 1'b1;
        end

        // R8: reset in mid-stream
        @(negedge clk);
        band_sel = 1'b0;
        rst_n = 1'b0;
        put(1234, 1'b1, 3);
        check(out_valid == 1'b0, "R8 mid reset valid", int'(out_valid), 0);
        check(out_rise == '0 && out_fall == '0, "R8 mid reset data", int'(out_rise), 0);
        rst_n = 1'b1;
        put(-700, 1'b1, 130);
        check(int'($signed(out_fall)) == -700, "R5 after reset", int'($signed(out_fall)), -700);

        finish_run();
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

endmodule